// File: doc/BRIEF.md
# Encoded Arithmetic, Logic and Shift Function Unit

This block evaluates one of fifteen operations on two W-bit operands and presents a W-bit result with four status flags. The 4-bit function code is not decoded into one-hot controls. Its bits drive the datapath directly. The lowest bit is the adder carry-in. The middle pair chooses the adder's second operand and, shifted down by one position, the logic operation. The top bit splits arithmetic from logic. When both of the top two bits are set, the result comes from a one-position shifter that acts on B.

The operation itself is combinational. In line with an FPGA-oriented code base, the result and flags are captured in output registers. Operands and function code presented before a rising clock edge appear at the outputs after that edge. A synchronous active-high reset clears the outputs.

Top module: `func_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become F=0, V=0, C=0, N=0, Z=1. Otherwise the outputs after each rising edge reflect the inputs sampled at that edge.
- R2: For codes with bit 3 = 0, F = (A + Y + code[0]) mod 2^W. Y depends on code[2:1]: 00 all zeros, 01 B, 10 bitwise NOT B, 11 all ones. This gives 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1 and 0111 A.
- R3: For arithmetic codes, C is the carry out of the most significant bit of A + Y + code[0].
- R4: For arithmetic codes, V is the XOR of the carry into the most significant bit and the carry out of it (two's-complement overflow).
- R5: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R6: Code 1100 passes B. Code 1101 shifts B right by one with a zero entering the MSB. Code 1110 shifts B left by one with a zero entering bit 0.
- R7: For every code with bit 3 = 1, C and V are 0.
- R8: For every code, N equals the MSB of F, and Z is 1 exactly when F is all zeros.
- R9: Code 1111 produces F = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| fs_in | input | 4 | Function code |
| f_out | output | W | Registered result |
| v_out | output | 1 | Registered overflow flag |
| c_out | output | 1 | Registered carry flag |
| n_out | output | 1 | Registered negative flag |
| z_out | output | 1 | Registered zero flag |

## Verification
The output registers are reloaded on every edge, so a wrong result or flag lasts exactly one cycle. It is visible at the ports on the edge right after the offending operands are sampled. A bit of the function code wired to the wrong stage shows up in the vectors that differ only in that bit. Examples are A+B against A+B+1, and A+~B against A-1. A misrouted carry into the MSB shows up only in the overflow flag, for operand pairs that cross the signed range. For this reason the vectors include both positive and negative overflow cases.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic [3:0] {
    FC_LSHIFT = 4'b1110,
    FC_RSHIFT = 4'b1101,
    FC_PASSB  = 4'b1100,
    FC_UNUSED = 4'b1111
  } fcode_e;

  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_B    = 2'b01,
    YS_NOTB = 2'b10,
    YS_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } lsel_e;
endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   ysel,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import fu_pkg::*;
  localparam int LW = W - 1;

  logic [W-1:0] y;
  logic [W:0]   full;
  logic [LW:0]  low;

  always_comb begin
    unique case (ysel_e'(ysel))
      YS_ZERO: y = '0;
      YS_B:    y = b;
      YS_NOTB: y = ~b;
      default: y = '1;
    endcase
  end

  assign full = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
  assign low  = {1'b0, a[LW-1:0]} + {1'b0, y[LW-1:0]} + {{LW{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = full[W] ^ low[LW];
endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   lsel,
  output logic [W-1:0] res
);
  import fu_pkg::*;
  always_comb begin
    unique case (lsel_e'(lsel))
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] b,
  input  logic [3:0]   code,
  output logic [W-1:0] res
);
  import fu_pkg::*;
  always_comb begin
    unique case (fcode_e'(code))
      FC_PASSB:  res = b;
      FC_RSHIFT: res = {1'b0, b[W-1:1]};
      FC_LSHIFT: res = {b[W-2:0], 1'b0};
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/func_unit.sv
module func_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   fs_in,
  output logic [W-1:0] f_out,
  output logic         v_out,
  output logic         c_out,
  output logic         n_out,
  output logic         z_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] ar_res, lg_res, sh_res, f_next;
  logic         ar_c, ar_v, is_arith, take_shift;

  fu_arith #(.W(W)) u_arith (
    .a(a_in), .b(b_in), .ysel(fs_in[2:1]), .cin(fs_in[0]),
    .sum(ar_res), .cout(ar_c), .ovf(ar_v)
  );

  fu_logic #(.W(W)) u_logic (
    .a(a_in), .b(b_in), .lsel(fs_in[1:0]), .res(lg_res)
  );

  fu_shift #(.W(W)) u_shift (
    .b(b_in), .code(fs_in), .res(sh_res)
  );

  assign is_arith   = ~fs_in[3];
  assign take_shift = fs_in[3] & fs_in[2];

  always_comb begin
    if (take_shift)    f_next = sh_res;
    else if (is_arith) f_next = ar_res;
    else               f_next = lg_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out <= '0;
      v_out <= 1'b0;
      c_out <= 1'b0;
      n_out <= 1'b0;
      z_out <= 1'b1;
    end else begin
      f_out <= f_next;
      v_out <= is_arith & ar_v;
      c_out <= is_arith & ar_c;
      n_out <= f_next[MSB];
      z_out <= (f_next == '0);
    end
  end

  a_r7_flags_clear: assert property (@(posedge clk) disable iff (rst)
    fs_in[3] |=> (!c_out && !v_out));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    z_out == (f_out == '0));

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (rst)
    n_out == f_out[MSB]);

  a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (fs_in == 4'b1111) |=> (f_out == '0));

  a_r6_left_fill: assert property (@(posedge clk) disable iff (rst)
    (fs_in == 4'b1110) |=> !f_out[0]);

  a_r6_right_fill: assert property (@(posedge clk) disable iff (rst)
    (fs_in == 4'b1101) |=> !f_out[MSB]);

  a_r2_pass_a: assert property (@(posedge clk) disable iff (rst)
    (fs_in == 4'b0000) |=> (f_out == $past(a_in) && !c_out && !v_out));
endmodule

// File: tb/func_unit_bench.sv
`timescale 1ns/1ps
module func_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic [3:0]   fs_in;
  logic [W-1:0] f_out;
  logic         v_out, c_out, n_out, z_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  func_unit #(.W(W)) u_func_unit (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .fs_in(fs_in),
    .f_out(f_out), .v_out(v_out), .c_out(c_out), .n_out(n_out), .z_out(z_out)
  );

  // {code, A, B, expected F, expected C, expected V}
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0000, 8'h3C, 8'h55, 8'h3C, 1'b0, 1'b0},
    {4'b0001, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},
    {4'b0010, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},
    {4'b0010, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
    {4'b0011, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0},
    {4'b0100, 8'h05, 8'h03, 8'h01, 1'b1, 1'b0},
    {4'b0101, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0},
    {4'b0101, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},
    {4'b0110, 8'h00, 8'h12, 8'hFF, 1'b0, 1'b0},
    {4'b0110, 8'h80, 8'h12, 8'h7F, 1'b1, 1'b1},
    {4'b0111, 8'h00, 8'h34, 8'h00, 1'b1, 1'b0},
    {4'b1000, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
    {4'b1001, 8'hF0, 8'h3C, 8'hFC, 1'b0, 1'b0},
    {4'b1010, 8'hF0, 8'h3C, 8'hCC, 1'b0, 1'b0},
    {4'b1011, 8'hF0, 8'h3C, 8'h0F, 1'b0, 1'b0},
    {4'b1100, 8'hFF, 8'h3C, 8'h3C, 1'b0, 1'b0},
    {4'b1101, 8'hFF, 8'h81, 8'h40, 1'b0, 1'b0},
    {4'b1110, 8'hFF, 8'h81, 8'h02, 1'b0, 1'b0},
    {4'b1111, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0},
    {4'b1010, 8'hAA, 8'hAA, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] fs, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    fs_in = fs; a_in = a; b_in = b;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; fs_in = 4'b0010; a_in = 8'h11; b_in = 8'h22;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset F", f_out, 0);
    check("R1 reset C", c_out, 0);
    check("R1 reset V", v_out, 0);
    check("R1 reset N", n_out, 0);
    check("R1 reset Z", z_out, 1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [29:0] e;
      e = VEC[i];
      apply(e[29:26], e[25:18], e[17:10]);
      if (!e[29]) begin
        check("R2 arith F", f_out, e[9:2]);
        check("R3 carry", c_out, e[1]);
        check("R4 overflow", v_out, e[0]);
      end else begin
        if (e[29:26] == 4'b1111) check("R9 unused F", f_out, 0);
        else if (e[28]) check("R6 shift F", f_out, e[9:2]);
        else check("R5 logic F", f_out, e[9:2]);
        check("R7 C clear", c_out, 0);
        check("R7 V clear", v_out, 0);
      end
      check("R8 N flag", n_out, e[9]);
      check("R8 Z flag", z_out, (e[9:2] == 8'h00));
    end

    // R1: one-edge latency, result follows new inputs on the next edge
    apply(4'b0010, 8'h01, 8'h01);
    check("R1 latency", f_out, 8'h02);
    @(negedge clk);
    fs_in = 4'b1011; a_in = 8'h00;
    #1 check("R1 held before edge", f_out, 8'h02);
    @(negedge clk);
    check("R1 after edge", f_out, 8'hFF);
    check("R8 N after NOT", n_out, 1);

    // R1: synchronous reset in mid-run clears a nonzero result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset F", f_out, 0);
    check("R1 mid reset Z", z_out, 1);
    check("R1 mid reset N", n_out, 0);
    rst = 1'b0;

    // R6: shifts at the ends of B
    apply(4'b1101, 8'h00, 8'h01);
    check("R6 right drops LSB", f_out, 8'h00);
    check("R8 Z after shift", z_out, 1);
    apply(4'b1110, 8'h00, 8'h80);
    check("R6 left drops MSB", f_out, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule